// File: doc/BRIEF.md
# Serial Sampling Converter Frame Responder

This block is the device-side digital port of a 12-bit serial sampling converter. A rising edge on the conversion strobe opens a frame. Rising edges of the serial clock then move the frame forward. On a single data line that can be tri-stated, the block shifts out a reference-ready status bit followed by the 12-bit sample, most significant bit first. A stand-in for the converter core supplies the sample word on a parallel input. The analog conversion itself is outside the block.

All logic runs on a fast system clock. The strobe and the serial clock are sampled as ordinary inputs, synchronous to that clock. A rising edge on either is seen in the system-clock cycle where the input is high and was low one cycle earlier. The data line and its enable come from registers, so they change one system-clock cycle after the serial-clock edge that advanced them.

The frame controller has four states:
- `FR_OFF`: the power-up state. No frame has run yet and the line is in high impedance.
- `FR_ACQ`: the lead-in edges before the status bit.
- `FR_SHIFT`: the status bit and the sample bits are on the line.
- `FR_DONE`: the frame is over and the last bit is held.

It has four transitions:
- start: `FR_OFF` or `FR_DONE` to `FR_ACQ`, on a strobe edge.
- first-out: `FR_ACQ` to `FR_SHIFT`, on the second serial edge.
- advance: `FR_SHIFT` to itself, on each later serial edge.
- finish: `FR_SHIFT` to `FR_DONE`, on the 14th serial edge.

Top module: `serial_frame_responder`

## Requirements
- R1: After reset, `sdata_oe` is 0 and `sdata` is high impedance. They stay that way, whatever serial-clock edges arrive, until the first strobe rising edge.
- R2: A strobe rising edge while no frame is running (state `FR_OFF` or `FR_DONE`) starts a frame. The first serial-clock rising edge after it leaves `sdata` and `sdata_oe` unchanged.
- R3: The second serial-clock rising edge of a frame drives `sdata` with the `ref_ready` value captured at the strobe edge and sets `sdata_oe` to 1.
- R4: Serial-clock edges 3 to 14 of a frame drive sample bits 11 down to 0 in that order, 13 output bits in all.
- R5: `sample_in` and `ref_ready` are captured in the cycle of the strobe edge. Changes to them later in the frame do not alter the bits sent.
- R6: Strobe rising edges are ignored from the frame start through the cycle of the 14th serial-clock edge, including one that falls in the same cycle as that edge.
- R7: After the 14th edge, `sdata` holds bit 0 of the sample and `sdata_oe` stays 1. Further serial-clock edges change nothing until a new strobe edge.
- R8: If a strobe rising edge and a serial-clock rising edge fall in the same cycle while no frame is running, the frame starts and that serial edge is not counted.
- R9: `sdata` changes only in the system-clock cycle after a counted serial-clock rising edge. A serial clock held high or low changes nothing.
- R10: Once `sdata_oe` is 1 it stays 1. A new frame keeps the previous last bit on the line until its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_strobe | input | 1 | Conversion strobe; a rising edge starts a frame |
| ser_clk | input | 1 | Serial clock; rising edges advance the frame |
| sample_in | input | 12 | Parallel sample word from the converter core |
| ref_ready | input | 1 | Reference-ready status from the converter core |
| sdata | output | 1 | Serial data line, high impedance while disabled |
| sdata_oe | output | 1 | Data line enable |

## Verification
A strobe edge and a serial-clock edge can land in the same system-clock cycle, and the block must then decide which one wins.

The bench provokes this in two places:
- At an idle frame start. The strobe must win, and the serial edge must not count.
- On the 14th edge of a running frame. The serial edge must win, and the strobe must be dropped.

The first case is judged by the line still holding the old bit on the next edge and showing the status bit on the edge after that. The second case is judged by sending two more edges with `ref_ready` set opposite to the held bit: the line must keep bit 0 of the sample.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        FR_OFF   = 2'd0,
        FR_ACQ   = 2'd1,
        FR_SHIFT = 2'd2,
        FR_DONE  = 2'd3
    } frame_state_t;
endpackage

// File: rtl/sfr_edge_detect.sv
module sfr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
    import sfr_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int LEAD_EDGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_rise,
    input  logic sck_rise,
    output logic load,
    output logic shift
);
    localparam int FRAME_EDGES = LEAD_EDGES + 1 + SAMPLE_W;
    localparam int CNT_W = $clog2(FRAME_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_EDGES);
    localparam logic [CNT_W-1:0] LEAD_CNT  = CNT_W'(LEAD_EDGES);

    frame_state_t state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n, edge_n;

    assign edge_n = cnt + 1'b1;

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            FR_OFF, FR_DONE: begin
                if (strobe_rise) begin
                    state_n = FR_ACQ;
                    cnt_n   = '0;
                end
            end
            FR_ACQ: begin
                if (sck_rise) begin
                    cnt_n = edge_n;
                    if (edge_n > LEAD_CNT)
                        state_n = (edge_n == LAST_EDGE) ? FR_DONE : FR_SHIFT;
                end
            end
            FR_SHIFT: begin
                if (sck_rise) begin
                    cnt_n = edge_n;
                    if (edge_n == LAST_EDGE) state_n = FR_DONE;
                end
            end
            default: state_n = FR_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        unique case (state)
            FR_OFF, FR_DONE: load  = strobe_rise;
            FR_ACQ:          shift = sck_rise && (edge_n > LEAD_CNT);
            FR_SHIFT:        shift = sck_rise;
            default: ;
        endcase
    end

    // R6
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FR_ACQ || state == FR_SHIFT) && strobe_rise && !sck_rise) |=> $stable(cnt));
    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_EDGE);
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_DONE && !strobe_rise) |=> (state == FR_DONE));
    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FR_OFF || state == FR_DONE) && strobe_rise) |=> (cnt == '0 && state == FR_ACQ));
endmodule

// File: rtl/sfr_shift_out.sv
module sfr_shift_out #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                ref_ready,
    output logic                bit_q,
    output logic                oe_q
);
    localparam int SR_W = SAMPLE_W + 1;

    logic [SR_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            if (load) begin
                sreg <= {ref_ready, sample_in};
            end else if (shift) begin
                sreg  <= {sreg[SR_W-2:0], 1'b0};
                bit_q <= sreg[SR_W-1];
                oe_q  <= 1'b1;
            end
        end
    end

    // R10
    oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |=> oe_q);
    // R9
    bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(bit_q));
    // R3
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(shift));
endmodule

// File: rtl/serial_frame_responder.sv
module serial_frame_responder #(
    parameter int SAMPLE_W   = 12,
    parameter int LEAD_EDGES = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_strobe,
    input  logic                ser_clk,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                ref_ready,
    output logic                sdata,
    output logic                sdata_oe
);
    logic strobe_rise, sck_rise, load, shift, bit_q, oe_q;

    sfr_edge_detect u_strobe_edge (
        .clk(clk), .rst_n(rst_n), .level_in(conv_strobe), .rise(strobe_rise)
    );

    sfr_edge_detect u_sck_edge (
        .clk(clk), .rst_n(rst_n), .level_in(ser_clk), .rise(sck_rise)
    );

    sfr_frame_ctrl #(.SAMPLE_W(SAMPLE_W), .LEAD_EDGES(LEAD_EDGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise), .sck_rise(sck_rise),
        .load(load), .shift(shift)
    );

    sfr_shift_out #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .sample_in(sample_in), .ref_ready(ref_ready),
        .bit_q(bit_q), .oe_q(oe_q)
    );

    assign sdata_oe = oe_q;
    assign sdata    = oe_q ? bit_q : 1'bz;
endmodule

// File: tb/serial_frame_responder_bench.sv
module serial_frame_responder_bench;
    localparam int SW = 12;
    localparam int NEDGE = SW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_strobe = 1'b0;
    logic ser_clk = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic ref_ready = 1'b0;
    wire  sdata;
    wire  sdata_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic prev_bit = 1'b0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    serial_frame_responder #(.SAMPLE_W(SW)) u_serial_frame_responder (
        .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .ser_clk(ser_clk),
        .sample_in(sample_in), .ref_ready(ref_ready),
        .sdata(sdata), .sdata_oe(sdata_oe)
    );

    task automatic chk_oe(input logic exp, input string req);
        total++;
        if (sdata_oe !== exp) begin
            bad++;
            $display("FAIL %s oe actual=%b expected=%b t=%0t", req, sdata_oe, exp, $time);
        end
    endtask

    task automatic chk_bit(input logic exp, input string req);
        total++;
        if (sdata_oe !== 1'b1 || sdata !== exp) begin
            bad++;
            $display("FAIL %s data actual=%b/oe=%b expected=%b t=%0t", req, sdata, sdata_oe, exp, $time);
        end
    endtask

    task automatic chk_prev(input string req);
        if (prev_oe) chk_bit(prev_bit, req);
        else         chk_oe(1'b0, req);
    endtask

    task automatic sck_up();
        @(negedge clk) ser_clk = 1'b1;
        @(negedge clk);
    endtask

    task automatic sck_down();
        ser_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe_pulse();
        @(negedge clk) conv_strobe = 1'b1;
        @(negedge clk) conv_strobe = 1'b0;
    endtask

    // mode 0 plain, 1 strobe mid-frame, 2 strobe with serial edge at start, 3 strobe with 14th edge
    task automatic run_frame(input logic [SW-1:0] val, input logic rf, input int mode);
        logic expb;
        sample_in = val;
        ref_ready = rf;
        if (mode == 2) begin
            @(negedge clk) begin conv_strobe = 1'b1; ser_clk = 1'b1; end
            @(negedge clk);
            chk_prev("R8");
            conv_strobe = 1'b0;
            ser_clk = 1'b0;
            @(negedge clk);
        end else begin
            strobe_pulse();
        end
        // R5: disturb the inputs after capture
        sample_in = ~val;
        ref_ready = ~rf;
        for (int k = 1; k <= NEDGE; k++) begin
            if (mode == 1 && k == 7) begin
                strobe_pulse();
                chk_bit(val[SW+2-6], "R6");
            end
            if (mode == 3 && k == NEDGE) begin
                ref_ready = ~val[0];
                @(negedge clk) begin conv_strobe = 1'b1; ser_clk = 1'b1; end
                @(negedge clk);
                conv_strobe = 1'b0;
            end else begin
                sck_up();
            end
            if (k == 1) begin
                chk_prev(mode == 2 ? "R8" : "R2");
            end else begin
                expb = (k == 2) ? rf : val[SW+2-k];
                chk_bit(expb, (k == 2) ? "R3" : "R4");
            end
            @(negedge clk);
            if (k == 1) chk_prev("R9");
            else chk_bit((k == 2) ? rf : val[SW+2-k], "R9");
            sck_down();
        end
        prev_bit = val[0];
        prev_oe = 1'b1;
        if (mode == 3) begin
            for (int j = 0; j < 2; j++) begin
                sck_up();
                chk_bit(val[0], "R6");
                sck_down();
            end
        end
        ref_ready = ~val[0];
        sck_up();
        chk_bit(val[0], "R7");
        sck_down();
        chk_oe(1'b1, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_oe(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_oe(1'b0, "R1");
        for (int j = 0; j < 3; j++) begin
            sck_up();
            chk_oe(1'b0, "R1");
            sck_down();
        end
        for (int f = 0; f < 48; f++) begin
            logic [SW-1:0] v;
            if (f < SW) v = SW'(1) << f;
            else if (f == SW) v = '1;
            else if (f == SW + 1) v = '0;
            else v = SW'((f * 1187 + 37) % 4096);
            run_frame(v, logic'(f[0] ^ f[2]), f % 4);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule